// File: doc/BRIEF.md
# Corner-Turn Address Generator

This block produces the command stream that turns a range-by-pulse sample matrix around in external memory. During the fill phase it writes each pulse's row of range samples to consecutive word addresses, using bursts of up to 64 words. Once every pulse of the frame has been accepted, it enters the drain phase. There it issues single-word reads at a stride of one row, so one range bin is collected across all pulses before the next bin is started. One sample (14-bit I plus 14-bit Q) takes one 32-bit word. A full 4096 x 512 frame is too large for on-chip storage, so the matrix is held off chip.

Software-independent operation: a `start` pulse given while the block is idle latches the base address, the row length (range bins per pulse, 1 to 4096) and the pulse count (1 to 512). Each command is presented with `cmd_valid`. It counts as issued only in a cycle where `cmd_ready` is also high. A one-cycle `frame_done` marks the end of the drain phase, after which the block is idle again. The block uses four states:
- IDLE waits for `start`.
- FILL issues write bursts.
- DRAIN issues strided reads.
- FINISH lasts one cycle and raises `frame_done`.

The transitions are:
- IDLE→FILL on `start`.
- FILL→DRAIN on the handshake of the last burst.
- DRAIN→FINISH on the handshake of the last read.
- FINISH→IDLE unconditionally.

Top module: `ctaddr_gen`

## Requirements
- R1: After reset, and while idle, `cmd_valid` and `frame_done` are low, whatever the value of `cmd_ready`.
- R2: A `start` sampled high in IDLE latches the base, row length R and pulse count P. In the next cycle `cmd_valid` is high with `cmd_write`=1 and `cmd_addr` equal to the base.
- R3: Write commands cover pulse p, bin r at address base + (p·R + r)·4. They run in arrival order: all bins of pulse 0 first, then pulse 1, and so on.
- R4: Each write burst has a `cmd_len` of 64 words, except at the end of a row. There the burst is shortened to the bins left in that row, so a burst never crosses a row end.
- R5: A command stays on `cmd_valid`/`cmd_addr`/`cmd_write`/`cmd_len` without change until a cycle in which `cmd_ready` is high. Only that handshake moves to the next command.
- R6: `cmd_write`=1 marks a write and 0 marks a read. No read is presented until every write burst of the frame has been handshaked.
- R7: Read commands have `cmd_len`=1. They are issued at address base + (p·R + b)·4 with p as the inner loop: all P pulses of bin 0, then bin 1, up to bin R-1.
- R8: `frame_done` is high for exactly one cycle, in the cycle after the last read handshake, with `cmd_valid` low. The block then returns to IDLE and accepts a new `start`.
- R9: A `start` given during FILL or DRAIN is ignored, along with any configuration presented with it. The running frame's command sequence and count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted in IDLE only) |
| base_addr | input | 32 | Byte address of the matrix origin |
| num_range | input | 13 | Range bins per pulse, 1..4096 |
| num_pulse | input | 10 | Pulses per frame, 1..512 |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Memory side accepts the command |
| cmd_write | output | 1 | 1 = write burst, 0 = single read |
| cmd_addr | output | 32 | Byte address of the command |
| cmd_len | output | 7 | Words in the command, 1..64 |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest situations to reach are the phase boundaries under back-pressure. These are the last write burst of a frame being held off by a low `cmd_ready` just before the FILL→DRAIN switch, and the last read being stalled just before FINISH. The bench reaches them by running the same frame shapes with `cmd_ready` driven always high, at random, and in long stall runs. It also runs extreme shapes: a single sample, a full-width 4096-bin row, and 512 pulses of two bins. A `start` carrying a different configuration is injected in the middle of a frame to confirm that the command stream does not move.

// File: rtl/ct_pkg.sv
package ct_pkg;
    typedef enum logic [1:0] {
        CT_IDLE,
        CT_FILL,
        CT_DRAIN,
        CT_FINISH
    } ct_state_e;
endpackage

// File: rtl/ct_wr_seq.sv
module ct_wr_seq #(
    parameter int RANGE_W = 13,
    parameter int PULSE_W = 10,
    parameter int LIN_W   = 23,
    parameter int BURST   = 64,
    parameter int LEN_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [RANGE_W-1:0] rows_len,
    input  logic [PULSE_W-1:0] pulses,
    output logic [LIN_W-1:0]   lin,
    output logic [LEN_W-1:0]   len,
    output logic               last
);
    logic [RANGE_W-1:0] col_q;
    logic [PULSE_W-1:0] row_q;
    logic [LIN_W-1:0]   lin_q;
    logic [RANGE_W-1:0] left;
    logic               row_end;

    always_comb begin
        left    = rows_len - col_q;
        row_end = (left <= RANGE_W'(BURST));
        len     = row_end ? left[LEN_W-1:0] : LEN_W'(BURST);
        last    = row_end && (row_q == pulses - PULSE_W'(1));
        lin     = lin_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
            lin_q <= '0;
        end else if (load) begin
            col_q <= '0;
            row_q <= '0;
            lin_q <= '0;
        end else if (step) begin
            lin_q <= lin_q + LIN_W'(len);
            if (row_end) begin
                col_q <= '0;
                row_q <= row_q + PULSE_W'(1);
            end else begin
                col_q <= col_q + RANGE_W'(BURST);
            end
        end
    end
endmodule

// File: rtl/ct_rd_seq.sv
module ct_rd_seq #(
    parameter int RANGE_W = 13,
    parameter int PULSE_W = 10,
    parameter int LIN_W   = 23
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [RANGE_W-1:0] rows_len,
    input  logic [PULSE_W-1:0] pulses,
    output logic [LIN_W-1:0]   lin,
    output logic               last
);
    logic [RANGE_W-1:0] bin_q;
    logic [PULSE_W-1:0] row_q;
    logic [LIN_W-1:0]   lin_q;
    logic               col_end;

    always_comb begin
        col_end = (row_q == pulses - PULSE_W'(1));
        last    = col_end && (bin_q == rows_len - RANGE_W'(1));
        lin     = lin_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q <= '0;
            row_q <= '0;
            lin_q <= '0;
        end else if (load) begin
            bin_q <= '0;
            row_q <= '0;
            lin_q <= '0;
        end else if (step) begin
            if (col_end) begin
                row_q <= '0;
                bin_q <= bin_q + RANGE_W'(1);
                lin_q <= LIN_W'(bin_q) + LIN_W'(1);
            end else begin
                row_q <= row_q + PULSE_W'(1);
                lin_q <= lin_q + LIN_W'(rows_len);
            end
        end
    end
endmodule

// File: rtl/ctaddr_gen.sv
module ctaddr_gen #(
    parameter int ADDR_W  = 32,
    parameter int RANGE_W = 13,
    parameter int PULSE_W = 10,
    parameter int BURST   = 64,
    localparam int LEN_W  = $clog2(BURST) + 1,
    localparam int LIN_W  = RANGE_W + PULSE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [RANGE_W-1:0] num_range,
    input  logic [PULSE_W-1:0] num_pulse,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic               cmd_write,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [LEN_W-1:0]   cmd_len,
    output logic               frame_done
);
    import ct_pkg::*;

    ct_state_e          state_q, state_d;
    logic [ADDR_W-1:0]  base_q;
    logic [RANGE_W-1:0] range_q;
    logic [PULSE_W-1:0] pulse_q;
    logic               accept;
    logic               hs;
    logic [LIN_W-1:0]   wr_lin, rd_lin, sel_lin;
    logic [LEN_W-1:0]   wr_len;
    logic               wr_last, rd_last;

    assign accept = start && (state_q == CT_IDLE);
    assign hs     = cmd_valid && cmd_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            range_q <= '0;
            pulse_q <= '0;
        end else if (accept) begin
            base_q  <= base_addr;
            range_q <= num_range;
            pulse_q <= num_pulse;
        end
    end

    ct_wr_seq #(
        .RANGE_W(RANGE_W), .PULSE_W(PULSE_W), .LIN_W(LIN_W),
        .BURST(BURST), .LEN_W(LEN_W)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .step(hs && (state_q == CT_FILL)),
        .rows_len(range_q), .pulses(pulse_q),
        .lin(wr_lin), .len(wr_len), .last(wr_last)
    );

    ct_rd_seq #(
        .RANGE_W(RANGE_W), .PULSE_W(PULSE_W), .LIN_W(LIN_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .step(hs && (state_q == CT_DRAIN)),
        .rows_len(range_q), .pulses(pulse_q),
        .lin(rd_lin), .last(rd_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CT_IDLE:   if (start) state_d = CT_FILL;
            CT_FILL:   if (hs && wr_last) state_d = CT_DRAIN;
            CT_DRAIN:  if (hs && rd_last) state_d = CT_FINISH;
            CT_FINISH: state_d = CT_IDLE;
            default:   state_d = CT_IDLE;
        endcase
    end

    always_comb begin
        cmd_valid  = 1'b0;
        cmd_write  = 1'b0;
        cmd_len    = LEN_W'(1);
        sel_lin    = rd_lin;
        frame_done = 1'b0;
        unique case (state_q)
            CT_IDLE: ;
            CT_FILL: begin
                cmd_valid = 1'b1;
                cmd_write = 1'b1;
                cmd_len   = wr_len;
                sel_lin   = wr_lin;
            end
            CT_DRAIN:  cmd_valid = 1'b1;
            CT_FINISH: frame_done = 1'b1;
            default: ;
        endcase
        cmd_addr = base_q + ADDR_W'({sel_lin, 2'b00});
    end
endmodule

// File: rtl/ctaddr_gen_chk.sv
module ctaddr_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 7,
    parameter int BURST  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_write,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              frame_done
);
    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr)
            && $stable(cmd_write) && $stable(cmd_len));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !cmd_valid);

    // R4
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_write |-> (cmd_len >= LEN_W'(1)) && (cmd_len <= LEN_W'(BURST)));

    // R7
    read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_write |-> cmd_len == LEN_W'(1));

    // R6
    no_write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_write |=> !(cmd_valid && cmd_write));
endmodule

bind ctaddr_gen ctaddr_gen_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST(BURST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .frame_done(frame_done)
);

// File: tb/tb_ctaddr_gen.sv
module tb_ctaddr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [12:0] num_range = '0;
    logic [9:0]  num_pulse = '0;
    logic        cmd_valid, cmd_ready, cmd_write, frame_done;
    logic [31:0] cmd_addr;
    logic [6:0]  cmd_len;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    ctaddr_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .num_range(num_range), .num_pulse(num_pulse), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .frame_done(frame_done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=0", cyc);
            summary();
        end
    end

    // mode 0: always ready, 1: random, 2: long stall runs
    task automatic run_frame(input int rl, input int pl, input logic [31:0] base,
                             input int mode, input bit poke);
        longint qa[$];
        bit     qw[$];
        int     ql[$];
        int     step = 0;
        int     issued = 0;
        int     total;
        bit     prev_rdy = 1;
        bit     first = 1;
        bit     pend_done = 0;
        for (int p = 0; p < pl; p++)
            for (int r = 0; r < rl; r += 64) begin
                qa.push_back(base + longint'((p * rl + r) * 4));
                qw.push_back(1);
                ql.push_back((rl - r) < 64 ? (rl - r) : 64);
            end
        for (int b = 0; b < rl; b++)
            for (int p = 0; p < pl; p++) begin
                qa.push_back(base + longint'((p * rl + b) * 4));
                qw.push_back(0);
                ql.push_back(1);
            end
        total = qa.size();
        @(negedge clk);
        chk("R1 idle valid", cmd_valid, 0);
        chk("R1 idle done", frame_done, 0);
        start = 1; base_addr = base; num_range = 13'(rl); num_pulse = 10'(pl);
        @(negedge clk);
        start = 0; base_addr = 32'hDEAD_0000; num_range = 13'd7; num_pulse = 10'd3;
        forever begin
            if (pend_done) begin
                chk("R8 done pulse", frame_done, 1);
                chk("R8 valid low at done", cmd_valid, 0);
                break;
            end
            chk("R8 no early done", frame_done, 0);
            if (first) begin
                chk("R2 first addr", cmd_addr, base);
                chk("R2 first is write", cmd_write, 1);
                first = 0;
            end
            chk(prev_rdy ? "R6 valid" : "R5 held valid", cmd_valid, 1);
            chk(qw[0] ? "R3 write addr" : "R7 read addr", cmd_addr, qa[0]);
            chk("R6 direction", cmd_write, qw[0]);
            chk(qw[0] ? "R4 burst len" : "R7 read len", cmd_len, ql[0]);
            if (poke && step == 5) start = 1;
            else start = 0;
            case (mode)
                0: prev_rdy = 1;
                1: prev_rdy = ($urandom % 2) == 1;
                default: prev_rdy = (step % 9) >= 6;
            endcase
            cmd_ready = prev_rdy;
            if (prev_rdy) begin
                void'(qa.pop_front()); void'(qw.pop_front()); void'(ql.pop_front());
                issued++;
                if (qa.size() == 0) pend_done = 1;
            end
            step++;
            @(negedge clk);
        end
        start = 0;
        if (poke) chk("R9 command count unchanged", issued, total);
        @(negedge clk);
        chk("R8 back to idle", cmd_valid, 0);
        chk("R8 done one cycle", frame_done, 0);
    endtask

    initial begin
        cmd_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", cmd_valid, 0);
        chk("R1 reset done", frame_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle with ready high", cmd_valid, 0);
        run_frame(130, 3, 32'h0000_1000, 0, 0);
        run_frame(64, 2, 32'h0010_0000, 1, 0);
        run_frame(1, 1, 32'h0000_0040, 0, 0);
        run_frame(5, 4, 32'h0002_0000, 2, 0);
        run_frame(200, 5, 32'h0300_0000, 1, 1);
        run_frame(130, 3, 32'h0000_1000, 2, 1);
        run_frame(4096, 2, 32'h1000_0000, 0, 0);
        run_frame(2, 512, 32'h2000_0000, 1, 0);
        summary();
    end
endmodule